// File: doc/BRIEF.md
# Fractional-Step Nanosecond Time-of-Day Counter

The block keeps a free-running time of day for a precision time protocol clock domain. Each core clock cycle, while counting is switched on, it adds a programmable step to a 96-bit accumulator. The upper 64 bits of the accumulator count whole nanoseconds and the lower 32 bits hold a binary fraction of a nanosecond. The step is a 32.32 fixed-point number of nanoseconds per cycle. Software sets it to (10^9 * 2^32) / f_clk to match the core clock, and then trims it slightly to pull the clock rate.

Software reaches the block through a small strobe-based register port with four 64-bit registers. The control register holds the run bit. The fine time word returns the low 32 nanosecond bits together with the fraction. The coarse time word returns the full 64-bit nanosecond count. The step register loads and returns the increment. A read of the fine word freezes a copy of the nanosecond count, so that the coarse read which follows belongs to the same instant.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset, the control, fine time, coarse time and step registers all read as zero, and `rd_valid` is low.
- R2: While running, every clock cycle adds the step, zero-extended, to the 96-bit accumulator. The accumulator holds nanoseconds in bits 95:32 and fraction in bits 31:0, and carries pass from the fraction into the nanoseconds and across the 32-bit nanosecond boundary.
- R3: Bit 0 of the control register (offset 0xF00) is the run bit. While it is 0, the time does not change. Its other bits are discarded and read back as 0.
- R4: A write to the step register (offset 0xF18) applies from the cycle after the write and leaves the time already accumulated unchanged. The register reads back the value written, with whole nanoseconds in bits 63:32 and fraction in bits 31:0.
- R5: A read of the coarse time word (offset 0xF10) returns the 64-bit whole-nanosecond count, unless a snapshot is pending.
- R6: A read of the fine time word (offset 0xF08) returns nanosecond bits 31:0 in data bits 63:32 and the fraction in data bits 31:0. The same read stores the full nanosecond count as a snapshot and marks it pending.
- R7: A coarse read while a snapshot is pending returns the snapshot and clears the pending mark. The next coarse read returns the live count again.
- R8: Writes to the fine and coarse time words are ignored. They change neither the time nor the other registers.
- R9: Read data and `rd_valid` appear one cycle after `rd_en`, and `rd_valid` is low in every cycle that follows no read. A read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
The bench runs the nominal steps for a 50 MHz base clock at every multiplier from 1 to 16. Each run is stopped after a known number of cycles and compared with the exact product of cycles and step. A design that dropped the fractional carry, or that counted the cycle on which the run bit is written, would miss by a nanosecond or a whole step. An all-ones step pushes the count across the 32-bit nanosecond boundary, which exposes a truncated count. A step change in mid-run would expose a design that resets or skips time on the reload. Further tests issue a fine read, wait, then make two coarse reads; these catch a missing or sticky snapshot. Writes to the time words and reads of an unmapped offset show whether writes leak into the time or stray data appears on the read bus.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int NS_W    = 64;
  localparam int FRAC_W  = 32;
  localparam int STEP_W  = 64;
  localparam int DATA_W  = 64;
  localparam int ADDR_W  = 12;
  localparam int ACC_W   = NS_W + FRAC_W;
  localparam int LO_NS_W = DATA_W - FRAC_W;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'hF00;
  localparam logic [ADDR_W-1:0] OFS_FINE = 12'hF08;
  localparam logic [ADDR_W-1:0] OFS_CRSE = 12'hF10;
  localparam logic [ADDR_W-1:0] OFS_STEP = 12'hF18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_FINE,
    SEL_CRSE,
    SEL_STEP
  } reg_sel_e;
endpackage

// File: rtl/ptp_rst_sync.sv
module ptp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ptp_tod_accum.sv
module ptp_tod_accum
  import ptp_tod_pkg::*;
#(
  parameter int N_W = NS_W,
  parameter int F_W = FRAC_W,
  parameter int S_W = STEP_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           count_en,
  input  logic [S_W-1:0] step,
  output logic [N_W-1:0] ns,
  output logic [F_W-1:0] frac
);
  localparam int A_W = N_W + F_W;

  logic [A_W-1:0] acc_q;
  logic [A_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q + A_W'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (count_en) acc_q <= acc_d;
  end

  assign ns   = acc_q[A_W-1:F_W];
  assign frac = acc_q[F_W-1:0];
endmodule

// File: rtl/ptp_tod_regfile.sv
module ptp_tod_regfile
  import ptp_tod_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_A = OFS_CTRL,
  parameter logic [ADDR_W-1:0] FINE_A = OFS_FINE,
  parameter logic [ADDR_W-1:0] CRSE_A = OFS_CRSE,
  parameter logic [ADDR_W-1:0] STEP_A = OFS_STEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NS_W-1:0]   ns,
  input  logic [FRAC_W-1:0] frac,
  output logic              count_en,
  output logic [STEP_W-1:0] step,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  reg_sel_e          sel;
  logic              run_q, run_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [NS_W-1:0]   snap_q, snap_d;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvld_q;

  always_comb begin
    unique case (addr)
      CTRL_A:  sel = SEL_CTRL;
      FINE_A:  sel = SEL_FINE;
      CRSE_A:  sel = SEL_CRSE;
      STEP_A:  sel = SEL_STEP;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    run_d   = run_q;
    step_d  = step_q;
    snap_d  = snap_q;
    pend_d  = pend_q;
    rdata_d = '0;
    if (wr_en && sel == SEL_CTRL) run_d  = wdata[0];
    if (wr_en && sel == SEL_STEP) step_d = wdata;
    if (rd_en) begin
      unique case (sel)
        SEL_CTRL: rdata_d = DATA_W'(run_q);
        SEL_FINE: begin
          rdata_d = {ns[LO_NS_W-1:0], frac};
          snap_d  = ns;
          pend_d  = 1'b1;
        end
        SEL_CRSE: begin
          rdata_d = pend_q ? snap_q : ns;
          pend_d  = 1'b0;
        end
        SEL_STEP: rdata_d = step_q;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      step_q <= '0;
      snap_q <= '0;
      pend_q <= 1'b0;
      rvld_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      step_q <= step_d;
      snap_q <= snap_d;
      pend_q <= pend_d;
      rvld_q <= rd_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign count_en = run_q;
  assign step     = step_q;
  assign rdata    = rdata_q;
  assign rd_valid = rvld_q;
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int                RST_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_A     = OFS_CTRL,
  parameter logic [ADDR_W-1:0] FINE_A     = OFS_FINE,
  parameter logic [ADDR_W-1:0] CRSE_A     = OFS_CRSE,
  parameter logic [ADDR_W-1:0] STEP_A     = OFS_STEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  logic              rst_n_core;
  logic              count_en;
  logic [STEP_W-1:0] step;
  logic [NS_W-1:0]   ns;
  logic [FRAC_W-1:0] frac;

  ptp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_core)
  );

  ptp_tod_accum #(.N_W(NS_W), .F_W(FRAC_W), .S_W(STEP_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n_core),
    .count_en (count_en),
    .step     (step),
    .ns       (ns),
    .frac     (frac)
  );

  ptp_tod_regfile #(
    .CTRL_A(CTRL_A), .FINE_A(FINE_A), .CRSE_A(CRSE_A), .STEP_A(STEP_A)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_core),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .ns       (ns),
    .frac     (frac),
    .count_en (count_en),
    .step     (step),
    .rdata    (rdata),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/ptp_tod_counter_chk.sv
module ptp_tod_counter_chk
  import ptp_tod_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_A = OFS_CTRL,
  parameter logic [ADDR_W-1:0] STEP_A = OFS_STEP
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              rd_valid,
  input logic              count_en,
  input logic [STEP_W-1:0] step,
  input logic [NS_W-1:0]   ns,
  input logic [FRAC_W-1:0] frac
);
  // R2
  accum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |=> {ns, frac} == $past({ns, frac}) + ACC_W'($past(step)));

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> $stable({ns, frac}));

  // R3
  run_bit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_A) |=> count_en == $past(wdata[0]));

  // R4
  step_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == STEP_A) |=> step == $past(wdata));

  // R9
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind ptp_tod_counter ptp_tod_counter_chk #(.CTRL_A(CTRL_A), .STEP_A(STEP_A)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_core),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rd_valid (rd_valid),
  .count_en (count_en),
  .step     (step),
  .ns       (ns),
  .frac     (frac)
);

// File: tb/ptp_tod_counter_test.sv
module ptp_tod_counter_test;
  localparam logic [11:0] A_CTRL = 12'hF00;
  localparam logic [11:0] A_FINE = 12'hF08;
  localparam logic [11:0] A_CRSE = 12'hF10;
  localparam logic [11:0] A_STEP = 12'hF18;
  localparam logic [11:0] A_NONE = 12'hF20;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [11:0] addr;
  logic [63:0] wdata;
  logic [63:0] rdata;
  logic        rd_valid;

  int checks;
  int failures;
  longint unsigned cyc;
  longint unsigned last_edge;
  logic [63:0] rv;
  bit done;

  ptp_tod_counter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    last_edge = cyc;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    last_edge = cyc;
    d = rdata;
    checks++;
    if (rd_valid !== 1'b1) begin
      failures++;
      $display("FAIL R9 rd_valid actual=%b expected=1", rd_valid);
    end
  endtask

  function automatic logic [127:0] total(input longint unsigned n, input logic [63:0] s);
    return 128'(n) * 128'(s);
  endfunction

  initial begin
    checks = 0; failures = 0; done = 0;
    forever begin
      @(posedge clk);
      if (cyc > 200000 && !done) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<200000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [127:0] t;
    logic [127:0] t2;
    longint unsigned a_edge, b_edge, c_edge, r1;
    logic [63:0] s1, s2, v1, v2;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    do_reset();

    // R1: reset state
    chk("R1 rd_valid", 64'(rd_valid), 64'd0);
    rd(A_CTRL, rv); chk("R1 ctrl", rv, 64'd0);
    rd(A_FINE, rv); chk("R1 fine", rv, 64'd0);
    rd(A_CRSE, rv); chk("R1 coarse", rv, 64'd0);
    rd(A_STEP, rv); chk("R1 step", rv, 64'd0);

    // R2 R3 R4 R5 R6: nominal steps for 50 MHz x m, m = 1..16
    for (int m = 1; m <= 16; m++) begin
      logic [63:0] s;
      s = (64'd1000000000 << 32) / (64'd50000000 * 64'(m));
      do_reset();
      wr(A_STEP, s);
      rd(A_STEP, rv); chk("R4 step readback", rv, s);
      wr(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFF);
      a_edge = last_edge;
      rd(A_CTRL, rv); chk("R3 run bit only", rv, 64'd1);
      repeat (37 * m) @(posedge clk);
      wr(A_CTRL, 64'd0);
      b_edge = last_edge;
      t = total(b_edge - a_edge, s);
      rd(A_CRSE, rv); chk("R2 R5 coarse after run", rv, t[95:32]);
      rd(A_FINE, rv); chk("R6 fine after run", rv, t[63:0]);
      repeat (9) @(negedge clk);
      rd(A_CRSE, rv); chk("R3 frozen while off", rv, t[95:32]);
    end

    // R2: carry across 32-bit nanosecond boundary with all-ones step
    do_reset();
    wr(A_STEP, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(A_CTRL, 64'd1); a_edge = last_edge;
    @(posedge clk);
    wr(A_CTRL, 64'd0); b_edge = last_edge;
    t = total(b_edge - a_edge, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_CRSE, rv); chk("R2 ns carry coarse", rv, t[95:32]);
    rd(A_FINE, rv); chk("R2 ns carry fine", rv, t[63:0]);

    // R4: step change while running keeps accumulated time
    do_reset();
    s1 = 64'h0000_0008_0000_0000;
    s2 = 64'h0000_0003_4000_0000;
    wr(A_STEP, s1);
    wr(A_CTRL, 64'd1); a_edge = last_edge;
    repeat (20) @(posedge clk);
    wr(A_STEP, s2); c_edge = last_edge;
    repeat (15) @(posedge clk);
    wr(A_CTRL, 64'd0); b_edge = last_edge;
    t = total(c_edge - a_edge, s1) + total(b_edge - c_edge, s2);
    rd(A_CRSE, rv); chk("R4 mid-run reload coarse", rv, t[95:32]);
    rd(A_FINE, rv); chk("R4 mid-run reload fine", rv, t[63:0]);

    // R6 R7: snapshot coherence while running
    do_reset();
    s1 = (64'd1000000000 << 32) / 64'd150000000;
    wr(A_STEP, s1);
    wr(A_CTRL, 64'd1); a_edge = last_edge;
    repeat (50) @(posedge clk);
    rd(A_FINE, rv); r1 = last_edge;
    t = total(r1 - a_edge - 1, s1);
    chk("R6 fine live", rv, t[63:0]);
    repeat (7) @(posedge clk);
    rd(A_CRSE, rv); chk("R7 coarse returns snapshot", rv, t[95:32]);
    rd(A_CRSE, rv);
    t2 = total(last_edge - a_edge - 1, s1);
    chk("R7 snapshot cleared, live coarse", rv, t2[95:32]);
    chk("R5 live coarse advanced", 64'(rv != t[95:32]), 64'd1);

    // R8: writes to time words ignored
    wr(A_CTRL, 64'd0); b_edge = last_edge;
    t = total(b_edge - a_edge, s1);
    wr(A_FINE, 64'hDEAD_BEEF_0123_4567);
    wr(A_CRSE, 64'h1234_5678_9ABC_DEF0);
    rd(A_CRSE, v1); chk("R8 coarse untouched", v1, t[95:32]);
    rd(A_FINE, v2); chk("R8 fine untouched", v2, t[63:0]);
    rd(A_STEP, rv); chk("R8 step untouched", rv, s1);
    rd(A_CTRL, rv); chk("R8 ctrl untouched", rv, 64'd0);

    // R9: unmapped offset and valid timing
    rd(A_NONE, rv); chk("R9 unmapped reads zero", rv, 64'd0);
    @(negedge clk);
    chk("R9 no valid without read", 64'(rd_valid), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule